// File: doc/BRIEF.md
# Carry-Skip Adder with Variable Group Widths

This block is a purely combinational adder. It takes two unsigned operands and a carry-in, and it produces the sum and a carry-out. The operand bits are split into consecutive groups, and a parameter list sets the width of each group.

Each bit computes its own generate and propagate terms. Inside a group the carry ripples from bit to bit. For every interior group, a bypass multiplexer checks whether all bits of the group propagate. If they do, the multiplexer sends the group's incoming carry straight to the next group and skips the ripple chain. The least and most significant groups never bypass and only ripple.

The widths can be narrow at both ends and wider in the middle, which keeps the worst carry path near the square root of the operand width. The per-group and per-bit carries are brought out as named internal wires so that a bound checker can observe them.

Top module: `csa_adder`

## Requirements
- R1: For all inputs, {cout, sum} equals a + b + cin as an unsigned sum of WIDTH+1 bits.
- R2: Each sum bit i equals a[i] XOR b[i] XOR the carry into bit i. The carry into bit 0 is cin.
- R3: When every bit of an interior group has a XOR b set, the carry leaving that group equals the carry entering it.
- R4: When every bit of a group has a and b both clear, the carry leaving the group is 0. When every bit has a and b both set, the carry leaving the group is 1.
- R5: cout equals the carry leaving the most significant group.
- R6: The widths in GROUP_WIDTHS must add up to WIDTH. Field k (bits 8k+7:8k) is the width of group k, and group 0 holds the least significant bits. Elaboration stops if the widths do not add up.
- R7: The adder gives correct results for different width lists, including lists whose end groups are narrower than the interior groups.
- R8: All-ones plus zero with cin = 1 gives a sum of zero and a cout of 1, with the carry crossing every group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top group |

## Verification
The hardest case to reach from the ports is a bypass multiplexer that selects the skip path while its group's incoming carry differs from what the group would produce on its own. To reach it, the ripple chain of a lower group has to deliver the carry, and every interior group above it has to be fully propagating. An exhaustive sweep of an 8-bit instance split into groups of 1, 3, 3 and 1 bits covers every such combination, in both carry-in states. A 16-bit instance with the default widths then receives targeted vectors: all-ones plus one, alternating bit patterns, and a carry generated low that must skip three interior groups. A stream of pseudo-random vectors follows these.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int MAX_GROUPS = 32;
  localparam int FIELD_BITS = 8;

  typedef logic [MAX_GROUPS*FIELD_BITS-1:0] width_list_t;

  // width of group k taken from the packed list
  function automatic int field_width(input width_list_t lst, input int k);
    return int'(lst[k*FIELD_BITS +: FIELD_BITS]);
  endfunction

  // bit index of the least significant bit of group k
  function automatic int group_lsb(input width_list_t lst, input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < MAX_GROUPS; j++) begin
      if (j < k) acc += field_width(lst, j);
    end
    return acc;
  endfunction

  // total of the first n widths
  function automatic int width_total(input width_list_t lst, input int n);
    return group_lsb(lst, n);
  endfunction

  function automatic logic bit_generate(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_propagate(input logic x, input logic y);
    return x ^ y;
  endfunction

  // one step of the ripple recurrence
  function automatic logic carry_step(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/csa_bit_pg.sv
module csa_bit_pg #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  import csa_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = bit_generate(op_x[i], op_y[i]);
    assign prop[i] = bit_propagate(op_x[i], op_y[i]);
  end

endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int GW        = 4,
  parameter bit USE_SKIP  = 1'b1
) (
  input  logic [GW-1:0] gen,
  input  logic [GW-1:0] prop,
  input  logic          c_in,
  output logic [GW-1:0] bit_c,
  output logic          all_prop,
  output logic          c_out
);
  import csa_pkg::*;

  logic [GW:0] chain;
  logic        ripple_out;

  assign chain[0] = c_in;

  for (genvar i = 0; i < GW; i++) begin : g_rip
    assign chain[i+1] = carry_step(gen[i], prop[i], chain[i]);
  end

  assign bit_c      = chain[GW-1:0];
  assign ripple_out = chain[GW];
  assign all_prop   = &prop;

  if (USE_SKIP) begin : g_skip
    assign c_out = all_prop ? c_in : ripple_out;
  end else begin : g_plain
    assign c_out = ripple_out;
  end

endmodule

// File: rtl/csa_sum.sv
module csa_sum #(
  parameter int W = 8
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] carry,
  output logic [W-1:0] s
);
  for (genvar i = 0; i < W; i++) begin : g_xor
    assign s[i] = prop[i] ^ carry[i];
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int                   WIDTH        = 16,
  parameter int                   NUM_GROUPS   = 5,
  parameter csa_pkg::width_list_t GROUP_WIDTHS = {8'd2, 8'd4, 8'd4, 8'd4, 8'd2}
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csa_pkg::*;

  localparam int LIST_TOTAL = width_total(GROUP_WIDTHS, NUM_GROUPS);

  // R6: the width list must cover the operand exactly
  if (LIST_TOTAL != WIDTH || NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_list
    $error("csa_adder: group widths add to %0d, WIDTH is %0d", LIST_TOTAL, WIDTH);
  end

  logic [WIDTH-1:0]      bit_gen;
  logic [WIDTH-1:0]      bit_prop;
  logic [WIDTH-1:0]      bit_carry;
  logic [NUM_GROUPS:0]   grp_carry;
  logic [NUM_GROUPS-1:0] grp_prop;

  csa_bit_pg #(.W(WIDTH)) u_pg (
    .op_x (a),
    .op_y (b),
    .gen  (bit_gen),
    .prop (bit_prop)
  );

  assign grp_carry[0] = cin;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    localparam int LSB  = group_lsb(GROUP_WIDTHS, k);
    localparam int GW   = field_width(GROUP_WIDTHS, k);
    localparam bit SKIP = (k != 0) && (k != NUM_GROUPS - 1);

    csa_group #(.GW(GW), .USE_SKIP(SKIP)) u_grp (
      .gen      (bit_gen[LSB +: GW]),
      .prop     (bit_prop[LSB +: GW]),
      .c_in     (grp_carry[k]),
      .bit_c    (bit_carry[LSB +: GW]),
      .all_prop (grp_prop[k]),
      .c_out    (grp_carry[k+1])
    );
  end

  csa_sum #(.W(WIDTH)) u_sum (
    .prop  (bit_prop),
    .carry (bit_carry),
    .s     (sum)
  );

  assign cout = grp_carry[NUM_GROUPS];

endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int                   WIDTH        = 16,
  parameter int                   NUM_GROUPS   = 5,
  parameter csa_pkg::width_list_t GROUP_WIDTHS = {8'd2, 8'd4, 8'd4, 8'd4, 8'd2}
) (
  input logic [WIDTH-1:0]      a,
  input logic [WIDTH-1:0]      b,
  input logic                  cin,
  input logic [WIDTH-1:0]      sum,
  input logic                  cout,
  input logic [WIDTH-1:0]      bit_carry,
  input logic [NUM_GROUPS:0]   grp_carry,
  input logic [NUM_GROUPS-1:0] grp_prop
);
  import csa_pkg::*;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      AST_SUM_VALUE: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}); // R1
      AST_BIT0_CARRY: assert (bit_carry[0] == cin); // R2
      AST_TOP_COUT: assert (cout == grp_carry[NUM_GROUPS]); // R5
      for (int i = 0; i < WIDTH; i++) begin
        AST_SUM_BIT: assert (sum[i] == (a[i] ^ b[i] ^ bit_carry[i])); // R2
      end
      for (int k = 0; k < NUM_GROUPS; k++) begin
        logic all_kill;
        logic all_gen;
        all_kill = 1'b1;
        all_gen  = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
          if (i >= group_lsb(GROUP_WIDTHS, k) && i < group_lsb(GROUP_WIDTHS, k + 1)) begin
            all_kill &= ~a[i] & ~b[i];
            all_gen  &= a[i] & b[i];
          end
        end
        if (k != 0 && k != NUM_GROUPS - 1 && grp_prop[k]) begin
          AST_SKIP_PASS: assert (grp_carry[k+1] == grp_carry[k]); // R3
        end
        if (all_kill) begin
          AST_GROUP_KILL: assert (grp_carry[k+1] == 1'b0); // R4
        end
        if (all_gen) begin
          AST_GROUP_GEN: assert (grp_carry[k+1] == 1'b1); // R4
        end
      end
    end
  end

endmodule

bind csa_adder csa_adder_chk #(
  .WIDTH(WIDTH), .NUM_GROUPS(NUM_GROUPS), .GROUP_WIDTHS(GROUP_WIDTHS)
) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .bit_carry(bit_carry), .grp_carry(grp_carry), .grp_prop(grp_prop)
);

// File: tb/csa_adder_test.sv
module csa_adder_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  // small config: groups of 1,3,3,1 bits (R7)
  logic [7:0]  sa, sb, ssum;
  logic        scin, scout;
  // default config: 16 bits, groups 2,4,4,4,2 (R7)
  logic [15:0] wa, wb, wsum;
  logic        wcin, wcout;

  csa_adder #(.WIDTH(8), .NUM_GROUPS(4), .GROUP_WIDTHS({8'd1, 8'd3, 8'd3, 8'd1})) uut (
    .a(sa), .b(sb), .cin(scin), .sum(ssum), .cout(scout)
  );

  csa_adder uut_wide (
    .a(wa), .b(wb), .cin(wcin), .sum(wsum), .cout(wcout)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wide_vec(input string req, input logic [15:0] x, input logic [15:0] y,
                          input logic c);
    logic [16:0] exp;
    @(posedge clk); #1;
    wa = x; wb = y; wcin = c;
    exp = 17'(x) + 17'(y) + 17'(c);
    @(negedge clk);
    check(req, {wcout, wsum}, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        total++; bad++;
        $display("FAIL watchdog expired got=%0d expected<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] lfsr;
    sa = '0; sb = '0; scin = 1'b0;
    wa = '0; wb = '0; wcin = 1'b0;
    @(negedge clk);
    // idle inputs at zero: R1 zero + zero
    check("R1 zero small", {9'd0, scout, ssum}, 17'd0);
    check("R1 zero wide", {wcout, wsum}, 17'd0);

    // exhaustive sweep of the 8-bit instance: R1 R2 R3 R4 R5
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          @(posedge clk); #1;
          sa = 8'(x); sb = 8'(y); scin = 1'(c);
          @(negedge clk);
          check("R1 R2 R3 R4 sweep", {8'd0, scout, ssum}, 17'(x + y + c));
          total++;
          if (scout !== 1'((x + y + c) >> 8)) begin
            bad++;
            $display("FAIL R5 cout got=%b expected=%b", scout, 1'((x + y + c) >> 8));
          end
        end
      end
    end

    // R8: carry crosses every group
    wide_vec("R8 all ones plus cin", 16'hFFFF, 16'h0000, 1'b1);
    wide_vec("R8 all ones plus one", 16'hFFFF, 16'h0001, 1'b0);
    wide_vec("R1 zero plus zero", 16'h0000, 16'h0000, 1'b0);
    wide_vec("R1 alternating", 16'hAAAA, 16'h5555, 1'b0);
    wide_vec("R3 alternating skip", 16'hAAAA, 16'h5555, 1'b1);
    wide_vec("R4 alternating gen", 16'hAAAA, 16'hAAAA, 1'b0);
    // R3: carry from group 0 skips three interior groups into the top group
    wide_vec("R3 skip interior", 16'h3FFF, 16'h0001, 1'b0);
    // R4: killing group blocks a low carry
    wide_vec("R4 kill group", 16'hFC3F, 16'h0001, 1'b0);
    wide_vec("R5 top cout", 16'h8000, 16'h8000, 1'b1);

    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] x;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wide_vec("R7 R1 random wide", x, lfsr, lfsr[3]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1'b1;
    $finish;
  end

endmodule